// File: doc/BRIEF.md
# Width-Selectable Parallel-to-Serial Transmitter

This block takes words from a parallel interface and emits them one bit at a time, most significant bit first. The parallel side and the serial side are both modelled inside one clock domain. A one-cycle `par_stb` pulse marks a rising edge of the parallel clock, and a one-cycle `ser_stb` pulse marks one serial bit time. Each parallel strobe writes the bus into a holding register. When the last bit of the word in flight has been sent, the serializer reloads from that holding register.

A static select picks the interface width. When `wide_mode` is high, all eight bus bits are sent. When it is low, only the upper half of the bus carries data. In both modes the top bus bit goes out first. After a master reset the serial output is held at 0 and `not_ready` stays high until the first parallel strobe primes the data path. A change of width is applied only when the next word is loaded.

Top module: `ptos_tx`

## Requirements
- R1: While reset is asserted and right after it, `not_ready` is 1 and `ser_out` is 0, whatever is applied to the data bus.
- R2: Until the first `par_stb` after reset, `not_ready` stays 1 and `ser_out` stays 0. Serial strobes have no effect in this state.
- R3: The first `par_stb` after reset captures `par_data`. On the next cycle `not_ready` is 0 and `ser_out` shows bit 7 of that word. The block stays ready until the next reset.
- R4: With `wide_mode`=1, a word leaves on `ser_out` as bit 7, 6, ..., 0. Each `ser_stb` advances exactly one bit, and `ser_out` is stable in cycles with no `ser_stb`.
- R5: With `wide_mode`=0, a word leaves as bits 7, 6, 5, 4. Bits 3..0 never reach `ser_out`. The next word begins right after bit 4.
- R6: The `ser_stb` that ends a word loads the most recently captured parallel word, and its bit 7 appears on `ser_out` on the following cycle.
- R7: If no new `par_stb` arrives during a word, the holding register still holds that word, so it is sent again.
- R8: A change of `wide_mode` in the middle of a word does not alter the length of that word. The new width applies from the next word on.
- R9: A `par_stb` that arrives in the middle of a word does not disturb the bits of that word still to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| par_stb | input | 1 | One-cycle pulse marking a parallel-clock rising edge |
| par_data | input | 8 | Parallel word; bit 7 is sent first |
| wide_mode | input | 1 | 1: 8-bit word, 0: 4-bit word on bits 7..4 |
| ser_stb | input | 1 | One-cycle pulse marking one serial bit time |
| ser_out | output | 1 | Serial data, 0 while not ready |
| not_ready | output | 1 | High from reset until the first parallel strobe |

## Verification
The bench watches the gap between reset and the first parallel strobe. A design that counted serial strobes in that window would start mid-word or leak the reset contents of its registers. It also sends narrow words whose low nibbles differ from the next word's top bits. A serializer that did not stop at bit 4 would show the ignored nibble. A width flip in the middle of a word is also exercised: a design that sampled the select on every bit would cut the word short or stretch it. Parallel strobes placed mid-word and words left without a successor catch a design that loads the holding register too early, or one that clears it after use.

// File: rtl/ptos_pkg.sv
package ptos_pkg;
   // index of the last bit sent in a word, counted from the first (0)
   function automatic int unsigned final_bit(input logic wide, input int unsigned full_w,
                                             input int unsigned half_w);
      return wide ? full_w - 1 : half_w - 1;
   endfunction
endpackage

// File: rtl/ptos_hold_reg.sv
module ptos_hold_reg #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned LANE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int unsigned LANES = WORD_W / LANE_W;

   generate
      if (WORD_W % LANE_W != 0) begin : g_bad_lane
         $error("ptos_hold_reg: WORD_W must be a multiple of LANE_W");
      end
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [LANE_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= '0;
            else if (cap_en) q <= din[ln*LANE_W +: LANE_W];
         end
         assign dout[ln*LANE_W +: LANE_W] = q;
      end
   endgenerate
endmodule

// File: rtl/ptos_init_ctl.sv
module ptos_init_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic par_stb,
   output logic ready,
   output logic prime
);
   assign prime = par_stb & ~ready;

   always_ff @(posedge clk) begin
      if (!rst_n)     ready <= 1'b0;
      else if (prime) ready <= 1'b1;
   end
endmodule

// File: rtl/ptos_shifter.sv
module ptos_shifter
   import ptos_pkg::*;
#(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic              prime,
   input  logic [WORD_W-1:0] prime_word,
   input  logic [WORD_W-1:0] hold_word,
   input  logic              ser_stb,
   input  logic              wide_sel,
   output logic              msb
);
   localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CW-1:0] LAST_WIDE   = CW'(final_bit(1'b1, WORD_W, NARROW_W));
   localparam logic [CW-1:0] LAST_NARROW = CW'(final_bit(1'b0, WORD_W, NARROW_W));

   logic [WORD_W-1:0] sh;
   logic [CW-1:0]     pos;
   logic              wide_q;
   logic [CW-1:0]     last_pos;
   logic              at_end;

   assign last_pos = wide_q ? LAST_WIDE : LAST_NARROW;
   assign at_end   = (pos == last_pos);
   assign msb      = sh[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh     <= '0;
         pos    <= '0;
         wide_q <= 1'b1;
      end else if (prime) begin
         sh     <= prime_word;
         pos    <= '0;
         wide_q <= wide_sel;
      end else if (ready && ser_stb) begin
         if (at_end) begin
            sh     <= hold_word;
            pos    <= '0;
            wide_q <= wide_sel;
         end else begin
            sh  <= sh << 1;
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ptos_tx.sv
module ptos_tx #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned NARROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_stb,
   input  logic [WORD_W-1:0] par_data,
   input  logic              wide_mode,
   input  logic              ser_stb,
   output logic              ser_out,
   output logic              not_ready
);
   logic              ready;
   logic              prime;
   logic [WORD_W-1:0] hold_word;
   logic              msb;

   generate
      if (NARROW_W == 0 || NARROW_W >= WORD_W) begin : g_bad_width
         $error("ptos_tx: NARROW_W must lie in 1..WORD_W-1");
      end
   endgenerate

   ptos_init_ctl u_init (
      .clk     (clk),
      .rst_n   (rst_n),
      .par_stb (par_stb),
      .ready   (ready),
      .prime   (prime)
   );

   ptos_hold_reg #(.WORD_W(WORD_W), .LANE_W(NARROW_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (par_stb),
      .din    (par_data),
      .dout   (hold_word)
   );

   ptos_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready      (ready),
      .prime      (prime),
      .prime_word (par_data),
      .hold_word  (hold_word),
      .ser_stb    (ser_stb),
      .wide_sel   (wide_mode),
      .msb        (msb)
   );

   assign ser_out   = ready & msb;
   assign not_ready = ~ready;
endmodule

// File: rtl/ptos_tx_chk.sv
module ptos_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic par_stb,
   input logic ser_stb,
   input logic ser_out,
   input logic not_ready
);
   // R1/R2: output quiet while not primed
   a_r2_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
      not_ready |-> (ser_out == 1'b0));

   a_r2_wait_prime: assert property (@(posedge clk) disable iff (!rst_n)
      (not_ready && !par_stb) |=> not_ready);

   a_r3_primes: assert property (@(posedge clk) disable iff (!rst_n)
      (not_ready && par_stb) |=> !not_ready);

   a_r3_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !not_ready |=> !not_ready);

   a_r4_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!not_ready && !ser_stb) |=> $stable(ser_out));
endmodule

bind ptos_tx ptos_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .par_stb   (par_stb),
   .ser_stb   (ser_stb),
   .ser_out   (ser_out),
   .not_ready (not_ready)
);

// File: tb/tb_ptos_tx.sv
module tb_ptos_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       par_stb = 1'b0;
   logic [7:0] par_data = 8'h00;
   logic       wide_mode = 1'b1;
   logic       ser_stb = 1'b0;
   logic       ser_out;
   logic       not_ready;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   ptos_tx dut (
      .clk(clk), .rst_n(rst_n), .par_stb(par_stb), .par_data(par_data),
      .wide_mode(wide_mode), .ser_stb(ser_stb), .ser_out(ser_out), .not_ready(not_ready)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pstrobe(input logic [7:0] w);
      par_data = w; par_stb = 1'b1;
      @(negedge clk);
      par_stb = 1'b0; par_data = 8'h00;
   endtask

   task automatic sstrobe();
      ser_stb = 1'b1;
      @(negedge clk);
      ser_stb = 1'b0;
   endtask

   task automatic expect_bits(input string tag, input logic [7:0] w, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         chk(tag, ser_out, w[i]);
         sstrobe();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; par_data = 8'hFF;
      idle(1);
      chk("R1 not_ready in reset", not_ready, 1'b1);
      chk("R1 ser_out in reset", ser_out, 1'b0);
      idle(2);
      rst_n = 1'b1; par_data = 8'h00;
      idle(1);
      chk("R1 not_ready after reset", not_ready, 1'b1);
      chk("R1 ser_out after reset", ser_out, 1'b0);
   endtask

   task automatic t_unprimed();
      do_reset();
      par_data = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         sstrobe();
         chk("R2 ser_out before prime", ser_out, 1'b0);
         chk("R2 not_ready before prime", not_ready, 1'b1);
      end
      par_data = 8'h00;
   endtask

   task automatic t_wide();
      do_reset();
      wide_mode = 1'b1;
      idle(2);
      pstrobe(8'hB4);
      chk("R3 not_ready cleared", not_ready, 1'b0);
      chk("R3 first bit", ser_out, 1'b1);
      idle(5);
      chk("R4 stable without strobe", ser_out, 1'b1);
      expect_bits("R4 wide word", 8'hB4, 7, 5);
      pstrobe(8'h3C);
      idle(3);
      expect_bits("R9 word in flight", 8'hB4, 4, 0);
      expect_bits("R6 next word loaded", 8'h3C, 7, 0);
      expect_bits("R7 word repeated", 8'h3C, 7, 0);
      chk("R3 stays ready", not_ready, 1'b0);
   endtask

   task automatic t_narrow();
      do_reset();
      wide_mode = 1'b0;
      idle(1);
      pstrobe(8'hA5);
      expect_bits("R5 narrow word", 8'hA5, 7, 6);
      pstrobe(8'h6F);
      expect_bits("R5 narrow word", 8'hA5, 5, 4);
      expect_bits("R5 low nibble skipped", 8'h6F, 7, 4);
      expect_bits("R7 narrow repeat", 8'h6F, 7, 4);
   endtask

   task automatic t_width_change();
      do_reset();
      wide_mode = 1'b1;
      idle(1);
      pstrobe(8'hC3);
      expect_bits("R8 wide before switch", 8'hC3, 7, 5);
      wide_mode = 1'b0;
      pstrobe(8'h9A);
      expect_bits("R8 wide word kept", 8'hC3, 4, 0);
      expect_bits("R8 narrow after boundary", 8'h9A, 7, 6);
      wide_mode = 1'b1;
      expect_bits("R8 narrow word kept", 8'h9A, 5, 4);
      expect_bits("R8 wide after boundary", 8'h9A, 7, 0);
   endtask

   initial begin
      idle(2);
      t_unprimed();
      t_wide();
      t_narrow();
      t_width_change();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule